// File: doc/BRIEF.md
# Endian Byte Lane Swapper

This block sits between a little-endian 32-bit local bus and a big-endian external bus. It rearranges the byte lanes of each transfer so that numeric values keep their meaning on both sides. Each transfer carries a size code (single byte, two-byte word or four-byte longword) and a direction flag. The flag says whether the local side is bus master or is being accessed as a slave. Master and slave traffic each have their own stored ordering bit. With that bit clear, word transfers exchange the bytes of each halfword and longword transfers exchange the two halfwords. With it set, words and longwords pass unchanged. A single byte is always moved to the other lane of its halfword.

The outbound (write) path and the inbound (read) path are permuted together in the same cycle, using the same lane mapping. Every mapping used here is its own inverse, so data written out and read back under the same settings returns unchanged. Byte enables follow their data bytes. A parameter selects a registered output stage, which is on by default.

Top module: `endian_lane_swapper`

## Requirements
- R1: Size code 2'b00 (byte) moves lane i to lane i XOR 1 whatever the ordering bit; lane 0 is bits 7:0, lane 3 is bits 31:24.
- R2: Size code 2'b01 (word) with the selected ordering bit 0 exchanges the two bytes inside each 16-bit half.
- R3: Size code 2'b10 (longword) with the selected ordering bit 0 exchanges bits 31:16 with bits 15:0 and keeps byte order inside each half.
- R4: With the selected ordering bit 1, word and longword transfers pass through unchanged.
- R5: xfer_slave = 0 selects the master ordering bit and xfer_slave = 1 selects the slave ordering bit.
- R6: When cfg_we is 1 at a rising clock edge, cfg_mst_big and cfg_slv_big are stored and used from the next transfer on; while cfg_we is 0 those inputs have no effect.
- R7: After synchronous reset both ordering bits are 0 and all outputs read 0.
- R8: The read path (rd_data to loc_rd_data) uses the same mapping as the write path, so feeding a written result back returns the original value.
- R9: Byte enables are moved with the same lane mapping as their data bytes, on both paths.
- R10: With the default registered output, outputs show the result of the inputs present at the previous rising edge and hold until the next one.
- R11: Size code 2'b11 is handled exactly like a longword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Store the two ordering bits |
| cfg_mst_big | input | 1 | Ordering bit for master transfers (1 = pass through) |
| cfg_slv_big | input | 1 | Ordering bit for slave transfers (1 = pass through) |
| xfer_slave | input | 1 | 0 = master transfer, 1 = slave transfer |
| xfer_size | input | 2 | 00 byte, 01 word, 10 longword, 11 as longword |
| wr_data | input | 32 | Local-side write data |
| wr_be | input | 4 | Local-side write byte enables |
| rd_data | input | 32 | External-side read data |
| rd_be | input | 4 | External-side read byte enables |
| ext_wr_data | output | 32 | Write data in external lane order |
| ext_wr_be | output | 4 | Write byte enables in external lane order |
| loc_rd_data | output | 32 | Read data in local lane order |
| loc_rd_be | output | 4 | Read byte enables in local lane order |

## Verification
Data words with a distinct value in every byte, such as 0x44332211, reveal any lane placement error. Single-hot byte enables in each lane show where one byte goes. Running every size under both ordering bits separates a byte swap from a halfword swap and from pass-through. Opposite master and slave bits show which stored bit the direction flag picks. Feeding a write result back into the read path checks that write and read undo each other.

// File: rtl/els_pkg.sv
package els_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/els_key_sel.sv
// Picks the lane XOR key from the transfer size and the ordering bit.
module els_key_sel #(
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [1:0]       size,
  input  logic             big,
  output logic [IDX_W-1:0] key
);
  import els_pkg::*;
  localparam logic [IDX_W-1:0] PAIR_KEY = IDX_W'(1);
  localparam logic [IDX_W-1:0] HALF_KEY = IDX_W'(LANES / 2);

  always_comb begin
    unique case (xfer_size_e'(size))
      SZ_BYTE: key = PAIR_KEY;
      SZ_WORD: key = big ? '0 : PAIR_KEY;
      default: key = big ? '0 : HALF_KEY;
    endcase
  end
endmodule

// File: rtl/els_permute.sv
// Moves every byte lane (data and enable) to lane index XOR key.
module els_permute #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int IDX_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  be_in,
  input  logic [IDX_W-1:0]  key,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  be_out
);
  for (genvar o = 0; o < LANES; o++) begin : g_lane
    logic [IDX_W-1:0] src;
    always_comb begin
      src = IDX_W'(o) ^ key;
      dout[o*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
      be_out[o] = be_in[src];
    end
  end
endmodule

// File: rtl/els_out_stage.sv
// Optional output register with synchronous clear.
module els_out_stage #(
  parameter int W       = 72,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end
endmodule

// File: rtl/endian_lane_swapper.sv
module endian_lane_swapper #(
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_mst_big,
  input  logic              cfg_slv_big,
  input  logic              xfer_slave,
  input  logic [1:0]        xfer_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LANES-1:0]  rd_be,
  output logic [DATA_W-1:0] ext_wr_data,
  output logic [LANES-1:0]  ext_wr_be,
  output logic [DATA_W-1:0] loc_rd_data,
  output logic [LANES-1:0]  loc_rd_be
);
  localparam int BUS_W = 2 * (DATA_W + LANES);

  logic mst_big_q, slv_big_q, big_sel;
  logic [IDX_W-1:0]  key;
  logic [DATA_W-1:0] wr_perm, rd_perm;
  logic [LANES-1:0]  wbe_perm, rbe_perm;

  // Stored ordering bits, cleared by reset (R6, R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      mst_big_q <= 1'b0;
      slv_big_q <= 1'b0;
    end else if (cfg_we) begin
      mst_big_q <= cfg_mst_big;
      slv_big_q <= cfg_slv_big;
    end
  end

  assign big_sel = xfer_slave ? slv_big_q : mst_big_q;

  els_key_sel #(.LANES(LANES)) u_key (
    .size(xfer_size), .big(big_sel), .key(key)
  );

  els_permute #(.LANES(LANES), .LANE_W(LANE_W)) u_wr_perm (
    .din(wr_data), .be_in(wr_be), .key(key), .dout(wr_perm), .be_out(wbe_perm)
  );

  els_permute #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_perm (
    .din(rd_data), .be_in(rd_be), .key(key), .dout(rd_perm), .be_out(rbe_perm)
  );

  els_out_stage #(.W(BUS_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst),
    .d({wr_perm, wbe_perm, rd_perm, rbe_perm}),
    .q({ext_wr_data, ext_wr_be, loc_rd_data, loc_rd_be})
  );
endmodule

// File: rtl/endian_lane_swapper_chk.sv
module endian_lane_swapper_chk #(
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int DATA_W = LANES * LANE_W,
  localparam int HW     = DATA_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_slave,
  input logic [1:0]        xfer_size,
  input logic [DATA_W-1:0] wr_data,
  input logic [LANES-1:0]  wr_be,
  input logic [DATA_W-1:0] rd_data,
  input logic [LANES-1:0]  rd_be,
  input logic [DATA_W-1:0] ext_wr_data,
  input logic [LANES-1:0]  ext_wr_be,
  input logic [DATA_W-1:0] loc_rd_data,
  input logic [LANES-1:0]  loc_rd_be,
  input logic              mst_big_q,
  input logic              slv_big_q
);
  logic              v_d, big_d;
  logic [1:0]        sz_d;
  logic [DATA_W-1:0] wd_d, rd_d;
  logic [LANES-1:0]  wbe_d, rbe_d;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk) begin
      v_d   <= !rst;
      big_d <= xfer_slave ? slv_big_q : mst_big_q;
      sz_d  <= xfer_size;
      wd_d  <= wr_data;
      rd_d  <= rd_data;
      wbe_d <= wr_be;
      rbe_d <= rd_be;
    end

    // R7
    rst_clears_chk: assert property (@(posedge clk)
      rst |=> (ext_wr_data == '0 && ext_wr_be == '0 && loc_rd_data == '0 && loc_rd_be == '0));
  end else begin : g_now
    assign v_d   = 1'b1;
    assign big_d = xfer_slave ? slv_big_q : mst_big_q;
    assign sz_d  = xfer_size;
    assign wd_d  = wr_data;
    assign rd_d  = rd_data;
    assign wbe_d = wr_be;
    assign rbe_d = rd_be;
  end

  // R1
  byte_pair_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (v_d && sz_d == 2'b00) |->
      ext_wr_data[2*LANE_W-1:0] == {wd_d[LANE_W-1:0], wd_d[2*LANE_W-1:LANE_W]});

  // R3
  long_half_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (v_d && sz_d[1] && !big_d) |-> ext_wr_data == {wd_d[HW-1:0], wd_d[DATA_W-1:HW]});

  // R4
  direct_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (v_d && sz_d != 2'b00 && big_d) |-> (ext_wr_data == wd_d && ext_wr_be == wbe_d));

  // R8
  read_half_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (v_d && sz_d[1] && !big_d) |-> loc_rd_data == {rd_d[HW-1:0], rd_d[DATA_W-1:HW]});

  // R9
  be_count_kept_chk: assert property (@(posedge clk) disable iff (rst)
    v_d |-> ($countones(ext_wr_be) == $countones(wbe_d) &&
             $countones(loc_rd_be) == $countones(rbe_d)));
endmodule

bind endian_lane_swapper endian_lane_swapper_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/test_endian_lane_swapper.sv
module test_endian_lane_swapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_mst_big = 1'b0, cfg_slv_big = 1'b0;
  logic        xfer_slave = 1'b0;
  logic [1:0]  xfer_size = 2'b00;
  logic [31:0] wr_data = '0, rd_data = '0;
  logic [3:0]  wr_be = '0, rd_be = '0;
  logic [31:0] ext_wr_data, loc_rd_data;
  logic [3:0]  ext_wr_be, loc_rd_be;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  endian_lane_swapper i_endian_lane_swapper (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mst_big(cfg_mst_big),
    .cfg_slv_big(cfg_slv_big), .xfer_slave(xfer_slave), .xfer_size(xfer_size),
    .wr_data(wr_data), .wr_be(wr_be), .rd_data(rd_data), .rd_be(rd_be),
    .ext_wr_data(ext_wr_data), .ext_wr_be(ext_wr_be),
    .loc_rd_data(loc_rd_data), .loc_rd_be(loc_rd_be)
  );

  function automatic logic [31:0] exp_d(input logic [31:0] d, input logic [1:0] sz, input logic big);
    if (sz == 2'b00 || (sz == 2'b01 && !big)) return {d[23:16], d[31:24], d[7:0], d[15:8]};
    if (big) return d;
    return {d[15:0], d[31:16]};
  endfunction

  function automatic logic [3:0] exp_be(input logic [3:0] b, input logic [1:0] sz, input logic big);
    if (sz == 2'b00 || (sz == 2'b01 && !big)) return {b[2], b[3], b[0], b[1]};
    if (big) return b;
    return {b[1:0], b[3:2]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic m, input logic s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mst_big = m; cfg_slv_big = s;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one transfer, checked one edge later on both paths
  task automatic xfer(input string req, input logic slv, input logic [1:0] sz,
                      input logic [31:0] wd, input logic [3:0] wb,
                      input logic [31:0] rdv, input logic [3:0] rb, input logic big);
    @(negedge clk);
    xfer_slave = slv; xfer_size = sz; wr_data = wd; wr_be = wb; rd_data = rdv; rd_be = rb;
    @(posedge clk); #1;
    check(req, ext_wr_data, exp_d(wd, sz, big));
    check(req, {28'd0, ext_wr_be}, {28'd0, exp_be(wb, sz, big)});
    check(req, loc_rd_data, exp_d(rdv, sz, big));
    check(req, {28'd0, loc_rd_be}, {28'd0, exp_be(rb, sz, big)});
  endtask

  task automatic t_reset;
    wr_data = 32'hDEADBEEF; wr_be = 4'hF; rd_data = 32'h12345678; rd_be = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    check("R7 outputs zero", ext_wr_data | loc_rd_data, 32'd0);
    check("R7 be zero", {28'd0, ext_wr_be | loc_rd_be}, 32'd0);
    @(negedge clk); rst = 1'b0;
    // reset modes are 0: word swaps bytes on both directions
    xfer("R7 master default", 1'b0, 2'b01, 32'h44332211, 4'b0011, 32'h88776655, 4'b1100, 1'b0);
    xfer("R7 slave default", 1'b1, 2'b01, 32'hA1B2C3D4, 4'b0001, 32'h01020304, 4'b1000, 1'b0);
  endtask

  task automatic t_byte;
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0], m[0]);
      for (int l = 0; l < 4; l++)
        xfer("R1 R9 byte lane", l[0], 2'b00, 32'h44332211, 4'b0001 << l,
             32'hCAFEF00D, 4'b1000 >> l, m[0]);
    end
  endtask

  task automatic t_word_long;
    set_mode(1'b0, 1'b0);
    xfer("R2 word swap", 1'b0, 2'b01, 32'h44332211, 4'b1100, 32'h0BADF00D, 4'b0011, 1'b0);
    xfer("R3 long swap", 1'b0, 2'b10, 32'h44332211, 4'b0111, 32'h13579BDF, 4'b1110, 1'b0);
    set_mode(1'b1, 1'b1);
    xfer("R4 word direct", 1'b0, 2'b01, 32'h44332211, 4'b0011, 32'h55667788, 4'b1100, 1'b1);
    xfer("R4 long direct", 1'b1, 2'b10, 32'h44332211, 4'b1111, 32'h99AABBCC, 4'b0110, 1'b1);
  endtask

  task automatic t_direction;
    set_mode(1'b1, 1'b0);
    xfer("R5 master uses master bit", 1'b0, 2'b10, 32'h01234567, 4'b0011, 32'h89ABCDEF, 4'b1100, 1'b1);
    xfer("R5 slave uses slave bit", 1'b1, 2'b10, 32'h01234567, 4'b0011, 32'h89ABCDEF, 4'b1100, 1'b0);
    set_mode(1'b0, 1'b1);
    xfer("R5 master swap", 1'b0, 2'b01, 32'h01234567, 4'b0001, 32'h89ABCDEF, 4'b0100, 1'b0);
    xfer("R5 slave direct", 1'b1, 2'b01, 32'h01234567, 4'b0001, 32'h89ABCDEF, 4'b0100, 1'b1);
  endtask

  task automatic t_cfg_hold;
    set_mode(1'b0, 1'b0);
    @(negedge clk);
    cfg_mst_big = 1'b1; cfg_slv_big = 1'b1;   // cfg_we stays 0
    xfer("R6 master unchanged", 1'b0, 2'b10, 32'h44332211, 4'b0001, 32'h11223344, 4'b1000, 1'b0);
    xfer("R6 slave unchanged", 1'b1, 2'b10, 32'h44332211, 4'b0001, 32'h11223344, 4'b1000, 1'b0);
  endtask

  task automatic t_roundtrip;
    logic [31:0] ext;
    logic [3:0]  eb;
    for (int sz = 0; sz < 3; sz++) begin
      @(negedge clk);
      xfer_slave = 1'b0; xfer_size = sz[1:0]; wr_data = 32'hFEDC0A5B; wr_be = 4'b0110;
      @(posedge clk); #1;
      ext = ext_wr_data; eb = ext_wr_be;
      @(negedge clk);
      rd_data = ext; rd_be = eb;
      @(posedge clk); #1;
      check("R8 round trip data", loc_rd_data, 32'hFEDC0A5B);
      check("R8 round trip be", {28'd0, loc_rd_be}, 32'h6);
    end
  endtask

  task automatic t_latency;
    set_mode(1'b0, 1'b0);
    xfer("R10 prime", 1'b0, 2'b10, 32'h11110000, 4'b0011, 32'h0, 4'b0, 1'b0);
    @(negedge clk);
    wr_data = 32'h22223333; xfer_size = 2'b10;
    #2;
    check("R10 hold before edge", ext_wr_data, 32'h00001111);
    @(posedge clk); #1;
    check("R10 update after edge", ext_wr_data, 32'h33332222);
  endtask

  task automatic t_rsvd;
    set_mode(1'b0, 1'b1);
    xfer("R11 code 11 swap", 1'b0, 2'b11, 32'h44332211, 4'b0001, 32'h87654321, 4'b0100, 1'b0);
    xfer("R11 code 11 direct", 1'b1, 2'b11, 32'h44332211, 4'b0001, 32'h87654321, 4'b0100, 1'b1);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_byte();
    t_word_long();
    t_direction();
    t_cfg_hold();
    t_roundtrip();
    t_latency();
    t_rsvd();
    finish_run();
  end
endmodule